// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a cycle-level behavioural model of a synchronous SRAM with one shared data bus, built so that reads and writes can follow one another on every clock with no idle cycle between them. On each rising edge it registers an address, three chip selects, a load/advance control and a write enable. When an operation is accepted, the write data and the per-lane byte write strobes for it arrive on the next edge, and that data is committed to the array there. For a read, the stored word is driven combinationally during the cycle after the address edge. Because write data lags its address by one edge, the bus carries data of some transfer on every cycle whatever the mix of reads and writes.

A two-bit burst counter lets a single loaded address produce a sequence of four words. The sequence wraps, and it is linear or interleaved according to an asynchronous mode input. A suspend input freezes every internal register and causes all synchronous inputs to be ignored. An asynchronous active-low output enable can turn the bus drivers off at any moment. The shared bus is modelled as a data input, a data output and a drive flag. The pins are plain and carry no handshake: an SRAM accepts one transfer per clock and cannot apply back-pressure. The only form of stall is the suspend input.

Top module: `zt_sram`

## Requirements
- R1: After reset no operation is in flight: dq_drive is 0 and dq_out is all zeros.
- R2: A read is accepted on an edge where suspend=0, load_n=0, the chip is selected and wr_n=1. During the following cycle, dq_drive is 1 and dq_out is the stored word at that address.
- R3: A write is accepted on an edge where suspend=0, load_n=0, the chip is selected and wr_n=0. Its data is taken from dq_in on the next active edge and stored there. Lane l is bits [9l+8:9l], and lane l is written only when byte_wr_n[l]=0; the other lanes keep their old contents.
- R4: Reads and writes may alternate on every edge with no idle cycle. A read accepted on the same edge that carries the data of a write to the same address returns the newly written word.
- R5: The chip is selected when sel1_n=0, sel2=1 and sel3_n=0. An edge with load_n=0 and the chip deselected starts no operation, and dq_drive is 0 in the following cycle. A write accepted on the previous edge still has its data committed on that edge.
- R6: While suspend=1, all synchronous inputs are ignored and no state changes. dq_out and dq_drive keep their values, and a pending write commits on the first active edge after the suspend ends.
- R7: When out_en_n=1, dq_drive is 0 and dq_out is zero at once, with no clock edge needed. When out_en_n returns to 0, the pending read data reappears.
- R8: With burst_ilv=0, each edge with load_n=1 during an active burst moves to the next word. Word k of a burst loaded at address A is A with its two low bits replaced by (A[1:0]+k) mod 4.
- R9: With burst_ilv=1, word k of the burst uses the low bits A[1:0] XOR k. Burst writes use the same order.
- R10: The bus is not driven (dq_drive=0) during the cycle in which a write waits for its data.
- R11: An edge with load_n=1 when no operation is in flight leaves the block idle, and dq_drive stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| suspend | input | 1 | High: ignore inputs and hold all state |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low selects a write for a loaded address |
| byte_wr_n | input | LANES (4) | Per-lane write strobes, active low, sampled with write data |
| addr | input | ADDR_W (4) | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (asynchronous) |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W (36) | Write data from the shared bus |
| dq_out | output | LANES*LANE_W (36) | Read data onto the shared bus, zero when not driving |
| dq_drive | output | 1 | High when the block drives the shared bus |

## Verification
The bench sweeps every address of a 16-word configuration several times. The first sweep writes back-to-back with all lanes enabled, then reads everything back. This separates address decoding from data storage. A second sweep alternates a write and a read of the same address on every edge, with an address-derived byte mask. This exposes any lost cycle, a read that misses the word committed on the same edge, and lanes written when they should be masked. Further patterns cover the three deselect forms after a write, suspend windows with junk on the inputs, output-enable toggles in mid-cycle, and linear and interleaved bursts from all four start offsets, including the wrap and a burst write. Each of these isolates one control path.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // Low address bits of burst beat k, starting from base offset b.
  function automatic logic [1:0] beat_offset(logic [1:0] b, logic [1:0] k, logic ilv);
    beat_offset = ilv ? (b ^ k) : 2'(b + k);
  endfunction
endpackage

// File: rtl/zt_addr_phase.sv
module zt_addr_phase
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              load_n,
  input  logic              chip_sel,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  output logic              ph_valid,
  output logic              ph_write,
  output logic [ADDR_W-1:0] ph_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_valid <= 1'b0;
      ph_write <= 1'b0;
      hi_q     <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (!suspend) begin
      if (!load_n) begin
        if (chip_sel) begin
          ph_valid <= 1'b1;
          ph_write <= !wr_n;
          hi_q     <= addr[ADDR_W-1:2];
          base_q   <= addr[1:0];
          cnt_q    <= 2'd0;
        end else begin
          ph_valid <= 1'b0;
        end
      end else if (ph_valid) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign ph_addr = {hi_q, beat_offset(base_q, cnt_q, burst_ilv)};
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && !lane_wr_n[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    suspend,
  input  logic                    load_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        byte_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_ilv,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int WORD_W = LANES * LANE_W;

  logic              chip_sel;
  logic              ph_valid;
  logic              ph_write;
  logic [ADDR_W-1:0] ph_addr;
  logic              commit;
  logic [WORD_W-1:0] rd_word;

  assign chip_sel = !sel1_n && sel2 && !sel3_n;

  zt_addr_phase #(.ADDR_W(ADDR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .load_n(load_n),
    .chip_sel(chip_sel), .wr_n(wr_n), .addr(addr), .burst_ilv(burst_ilv),
    .ph_valid(ph_valid), .ph_write(ph_write), .ph_addr(ph_addr)
  );

  // Write data for the in-flight address lands on this edge.
  assign commit = !suspend && ph_valid && ph_write;

  zt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(commit), .lane_wr_n(byte_wr_n), .waddr(ph_addr),
    .wdata(dq_in), .raddr(ph_addr), .rdata(rd_word)
  );

  assign dq_drive = ph_valid && !ph_write && !out_en_n;
  assign dq_out   = dq_drive ? rd_word : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              suspend,
  input logic              load_n,
  input logic              chip_sel,
  input logic              wr_n,
  input logic              burst_ilv,
  input logic              out_en_n,
  input logic              dq_drive,
  input logic              ph_valid,
  input logic              ph_write,
  input logic [ADDR_W-1:0] ph_addr
);
  a_r2_read_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !load_n && chip_sel && wr_n) |=> (ph_valid && !ph_write));

  a_r3_write_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !load_n && chip_sel && !wr_n) |=> (ph_valid && ph_write));

  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !load_n && !chip_sel) |=> !dq_drive);

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> ($stable(ph_valid) && $stable(ph_write)));

  a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_drive);

  a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && load_n && ph_valid && !burst_ilv) |=>
      (burst_ilv || ph_addr[1:0] == 2'($past(ph_addr[1:0]) + 2'd1)));

  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ph_write |-> !dq_drive);

  a_r11_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && load_n && !ph_valid) |=> !ph_valid);
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .load_n(load_n),
  .chip_sel(chip_sel), .wr_n(wr_n), .burst_ilv(burst_ilv),
  .out_en_n(out_en_n), .dq_drive(dq_drive), .ph_valid(ph_valid),
  .ph_write(ph_write), .ph_addr(ph_addr)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam int K_DS1 = 0, K_RD = 1, K_WR = 2, K_ADV = 3, K_DS2 = 4, K_DS3 = 5;

  logic clk = 1'b0, rst_n = 1'b0, suspend = 1'b0, load_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0, wr_n = 1'b1;
  logic [LANES-1:0] byte_wr_n = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic burst_ilv = 1'b0, out_en_n = 1'b0;
  logic [WORD_W-1:0] dq_in = '0;
  logic [WORD_W-1:0] dq_out;
  logic dq_drive;

  always #(CLK_P/2) clk = ~clk;

  zt_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .load_n(load_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .wr_n(wr_n),
    .byte_wr_n(byte_wr_n), .addr(addr), .burst_ilv(burst_ilv),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model
  logic [WORD_W-1:0] mem [DEPTH];
  bit m_valid = 1'b0, m_write = 1'b0;
  logic [ADDR_W-3:0] m_hi = '0;
  logic [1:0] m_base = '0, m_cnt = '0;
  int g_seed = 0, g_mask = 0;

  function automatic logic [ADDR_W-1:0] m_addr();
    logic [1:0] lo;
    lo = burst_ilv ? (m_base ^ m_cnt) : 2'((int'(m_base) + int'(m_cnt)) % 4);
    return {m_hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] wdata(logic [ADDR_W-1:0] a, int seed);
    return WORD_W'(a) * 36'h0_1111_1111 + WORD_W'(seed) * 36'h3_0507_0B0D + 36'h5;
  endfunction

  function automatic logic [LANES-1:0] wmask(logic [ADDR_W-1:0] a, int mode);
    if (mode == 0) return '0;
    return LANES'(a) ^ LANES'(mode);
  endfunction

  task automatic check(string tag, logic [WORD_W-1:0] exp_dq, logic exp_drv);
    n_chk++;
    if (dq_drive !== exp_drv || dq_out !== exp_dq) begin
      n_bad++;
      $display("FAIL %s: drive=%0b dq=%h expected drive=%0b dq=%h",
               tag, dq_drive, dq_out, exp_drv, exp_dq);
    end
  endtask

  task automatic expect_model(string tag);
    if (m_valid && !m_write) check(tag, mem[m_addr()], 1'b1);
    else check(tag, '0, 1'b0);
  endtask

  // One clock: drive inputs, take the edge, update the model, check at negedge.
  task automatic step(int kind, logic [ADDR_W-1:0] a, bit sus, string tag);
    logic [ADDR_W-1:0] pa;
    logic [WORD_W-1:0] d;
    logic [LANES-1:0] m;
    pa = m_addr();
    suspend = sus;
    load_n  = (kind == K_ADV);
    sel1_n  = (kind == K_DS1);
    sel2    = (kind != K_DS2);
    sel3_n  = (kind == K_DS3);
    wr_n    = (kind != K_WR);
    addr    = a;
    if (sus) begin
      d = ~wdata(a, 77);
      m = '0;
    end else begin
      d = wdata(pa, g_seed);
      m = wmask(pa, g_mask);
    end
    dq_in = d;
    byte_wr_n = m;
    @(posedge clk);
    if (!sus) begin
      if (m_valid && m_write)
        for (int l = 0; l < LANES; l++)
          if (!m[l]) mem[pa][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      if (kind == K_ADV) begin
        if (m_valid) m_cnt = m_cnt + 2'd1;
      end else if (kind == K_RD || kind == K_WR) begin
        m_valid = 1'b1;
        m_write = (kind == K_WR);
        m_hi = a[ADDR_W-1:2];
        m_base = a[1:0];
        m_cnt = 2'd0;
      end else begin
        m_valid = 1'b0;
      end
    end
    @(negedge clk);
    expect_model(tag);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0, 1'b0);

    // Back-to-back writes of every address, all lanes, then reads.
    g_seed = 1; g_mask = 0;
    for (int a = 0; a < DEPTH; a++) step(K_WR, ADDR_W'(a), 0, "R3 full write");
    step(K_DS1, '0, 0, "R5 commit after deselect");
    for (int a = 0; a < DEPTH; a++) step(K_RD, ADDR_W'(a), 0, "R2 read sweep");
    step(K_WR, 4'd1, 0, "R10 write phase quiet");

    // Alternate write/read of the same address with byte masks.
    g_seed = 2; g_mask = 6;
    for (int a = 0; a < DEPTH; a++) begin
      step(K_WR, ADDR_W'(a), 0, "R4 write");
      step(K_RD, ADDR_W'(a), 0, "R4 read after write");
    end
    step(K_DS1, '0, 0, "R5 idle");
    for (int a = DEPTH - 1; a >= 0; a--) step(K_RD, ADDR_W'(a), 0, "R3 masked lanes kept");

    // Each deselect form after a write.
    g_seed = 3; g_mask = 0;
    for (int v = 0; v < 3; v++) begin
      step(K_WR, ADDR_W'(v + 3), 0, "R10 write");
      step(v == 0 ? K_DS1 : (v == 1 ? K_DS2 : K_DS3), ADDR_W'(v), 0, "R5 deselect");
      step(K_RD, ADDR_W'(v + 3), 0, "R5 pending write completed");
      step(v == 0 ? K_DS3 : K_DS2, '0, 0, "R5 read then deselect");
    end

    // Suspend with junk on the inputs.
    step(K_RD, 4'd5, 0, "R2");
    step(K_WR, 4'd9, 1, "R6 held during suspend");
    step(K_DS2, 4'd0, 1, "R6 held during suspend");
    step(K_RD, 4'd6, 0, "R6 resumes");
    g_seed = 5;
    step(K_WR, 4'd7, 0, "R10");
    step(K_RD, 4'd8, 1, "R6 write waits");
    step(K_ADV, 4'd2, 1, "R6 write waits");
    step(K_RD, 4'd7, 0, "R6 write committed after suspend");

    // Asynchronous output enable.
    step(K_RD, 4'd2, 0, "R2");
    out_en_n = 1'b1;
    #1 check("R7 output forced off", '0, 1'b0);
    out_en_n = 1'b0;
    #1 check("R7 output restored", mem[2], 1'b1);
    @(negedge clk);

    // Bursts from every start offset, both orders.
    for (int ilv = 0; ilv < 2; ilv++) begin
      burst_ilv = ilv[0];
      for (int b = 0; b < 4; b++) begin
        step(K_RD, ADDR_W'(8 + b), 0, ilv ? "R9 load" : "R8 load");
        for (int k = 0; k < 5; k++) step(K_ADV, '0, 0, ilv ? "R9 beat" : "R8 beat");
      end
    end
    g_seed = 4; g_mask = 0;
    step(K_WR, 4'hD, 0, "R9 burst write");
    for (int k = 0; k < 3; k++) step(K_ADV, '0, 0, "R9 burst write beat");
    step(K_DS1, '0, 0, "R9 burst end");
    for (int a = 12; a < 16; a++) step(K_RD, ADDR_W'(a), 0, "R9 burst write order");
    burst_ilv = 1'b0;

    // Advance with nothing in flight.
    step(K_DS3, '0, 0, "R5");
    step(K_ADV, 4'd4, 0, "R11 idle advance");
    step(K_ADV, 4'd4, 0, "R11 idle advance");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule